// File: doc/BRIEF.md
# DMA Bus Grant Handshake

This block decides who owns the shared address/data bus: the processor core or an external DMA controller. Software opens the door for DMA by writing a one-bit enable through an internal I/O command; the enable is also driven out as a pin so the system can see it. The DMA controller asks for the bus by pulling an active-low request low. Ownership changes hands only on falling edges of the bus sync strobe. A grant is shown by the active-low acknowledge going low. The same grant puts every core bus and control driver into high impedance, turns the external transceivers toward the local bus, and disables the control buffers.

A request seen while the enable is high is held as pending. Clearing the enable after that point does not cancel the request. Clearing it during a grant does not revoke the grant either. Only requests that arrive while the enable is low are turned away. The controller gives the bus back by raising its request, and the acknowledge rises again on the next sync falling edge. The core is told to stall for as long as the grant is held.

All interfaces are plain level-and-strobe control pins. No data passes through the block, so it has no valid/ready channel and applies no back-pressure.

Top module: `dma_bus_arbiter`

## Requirements
- R1: `dma_en` is 0 after reset; a clock edge with `io_wr` = 1 loads `io_wr_val` into `dma_en`, which then holds until the next write.
- R2: While `dma_en` is 0 and no request is pending, a low `dma_req_n` is ignored: `dma_ack_n` stays 1 across sync falling edges.
- R3: A sync falling edge is a clock edge where `sync_n` is sampled 0 and was sampled 1 at the previous edge. On such an edge, a qualified request (low `dma_req_n` with `dma_en` = 1, or a pending request) drives `dma_ack_n` low.
- R4: A qualified request held low while `sync_n` does not fall never produces a grant.
- R5: During a grant, raising `dma_req_n` leaves `dma_ack_n` low until the next sync falling edge, at which `dma_ack_n` returns to 1.
- R6: A request sampled low while `dma_en` = 1 stays pending when `dma_en` is cleared before the sync falling edge, and it is still granted on that edge.
- R7: Clearing `dma_en` during a grant does not end it. After release, a new request made while `dma_en` = 0 is not granted.
- R8: `bus_oe` and `ctrl_oe` are all zeros (drivers high impedance) while `dma_ack_n` is 0, and all ones otherwise.
- R9: `xcvr_dir_n` and `ctrl_dis_n` are 0 while `dma_ack_n` is 0, and 1 otherwise.
- R10: `core_stall` is 1 exactly while `dma_ack_n` is 0.
- R11: A pending request cancelled by raising `dma_req_n` before a sync falling edge is not granted.
- R12: After reset, `dma_ack_n`, `xcvr_dir_n` and `ctrl_dis_n` are 1, `core_stall` is 0, and all driver enables are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| io_wr | input | 1 | I/O command strobe that writes the DMA enable |
| io_wr_val | input | 1 | Value written to the DMA enable |
| sync_n | input | 1 | Bus sync strobe, sampled every clock |
| dma_req_n | input | 1 | Active-low bus request from the DMA controller |
| dma_en | output | 1 | DMA enable as set by software |
| dma_ack_n | output | 1 | Active-low bus grant acknowledge |
| bus_oe | output | BUS_W | Per-bit enables of the address/data drivers (1 = drive) |
| ctrl_oe | output | CTRL_W | Enables of the strobe and cycle-type drivers (1 = drive) |
| xcvr_dir_n | output | 1 | Transceiver direction; 0 = drive toward the local bus |
| ctrl_dis_n | output | 1 | Active-low control buffer disable |
| core_stall | output | 1 | Holds the core while the bus is granted |

## Verification
The assertions take it for granted that `sync_n` and `dma_req_n` are already synchronous to `clk`, so each level is sampled the same way by every flop. They also assume `sync_n` is high while reset is asserted, so no falling edge appears to come out of reset. The stimulus changes inputs only on the falling clock edge and holds `sync_n` high during and just after reset. It shapes every sync falling edge as a clean high-to-low step that stays low for at least one full clock, so each strobe is detected exactly once.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  typedef enum logic [1:0] {
    ARB_IDLE  = 2'd0,
    ARB_PEND  = 2'd1,
    ARB_GRANT = 2'd2
  } arb_state_e;
endpackage

// File: rtl/dma_sync_edge.sv
module dma_sync_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_n,
  output logic sync_fall
);
  logic sync_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sync_q <= 1'b1;
    else        sync_q <= sync_n;
  end

  assign sync_fall = sync_q & ~sync_n;

  AST_FALL_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    sync_fall |=> !sync_fall); // R3
endmodule

// File: rtl/dma_en_reg.sv
module dma_en_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic io_wr,
  input  logic io_wr_val,
  output logic en_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)     en_q <= 1'b0;
    else if (io_wr) en_q <= io_wr_val;
  end

  AST_EN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    io_wr |=> (en_q == $past(io_wr_val))); // R1
  AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !io_wr |=> $stable(en_q)); // R1
endmodule

// File: rtl/dma_grant_fsm.sv
module dma_grant_fsm
  import dma_arb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en_q,
  input  logic sync_fall,
  input  logic req_n,
  output logic gnt_nxt,
  output logic gnt_q
);
  arb_state_e st_q, st_d;
  logic       new_req;

  assign new_req = ~req_n & en_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ARB_IDLE: begin
        if (new_req) st_d = sync_fall ? ARB_GRANT : ARB_PEND;
      end
      ARB_PEND: begin
        if (req_n)          st_d = ARB_IDLE;
        else if (sync_fall) st_d = ARB_GRANT;
      end
      ARB_GRANT: begin
        if (sync_fall && req_n) st_d = ARB_IDLE;
      end
      default: st_d = ARB_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= ARB_IDLE;
    else        st_q <= st_d;
  end

  assign gnt_nxt = (st_d == ARB_GRANT);
  assign gnt_q   = (st_q == ARB_GRANT);

  AST_GRANT_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gnt_q) |-> $past(sync_fall)); // R4
  AST_GRANT_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gnt_q) |-> ($past(!req_n) && ($past(en_q) || $past(st_q == ARB_PEND)))); // R2
  AST_RELEASE_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gnt_q) |-> ($past(sync_fall) && $past(req_n))); // R5
  AST_GRANT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_q && !req_n) |=> gnt_q); // R7
endmodule

// File: rtl/dma_drv_ctrl.sv
module dma_drv_ctrl #(
  parameter int BUS_W  = 16,
  parameter int CTRL_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gnt_nxt,
  input  logic              ack_n,
  output logic [BUS_W-1:0]  bus_oe,
  output logic [CTRL_W-1:0] ctrl_oe,
  output logic              xcvr_dir_n,
  output logic              ctrl_dis_n,
  output logic              core_stall
);
  for (genvar i = 0; i < BUS_W; i++) begin : g_bus
    always_ff @(posedge clk) begin
      if (!rst_n) bus_oe[i] <= 1'b1;
      else        bus_oe[i] <= ~gnt_nxt;
    end
  end

  for (genvar j = 0; j < CTRL_W; j++) begin : g_ctl
    always_ff @(posedge clk) begin
      if (!rst_n) ctrl_oe[j] <= 1'b1;
      else        ctrl_oe[j] <= ~gnt_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      xcvr_dir_n <= 1'b1;
      ctrl_dis_n <= 1'b1;
      core_stall <= 1'b0;
    end else begin
      xcvr_dir_n <= ~gnt_nxt;
      ctrl_dis_n <= ~gnt_nxt;
      core_stall <= gnt_nxt;
    end
  end

  AST_BUS_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe == '0) == !ack_n); // R8
  AST_BUS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    ack_n |-> (bus_oe == '1 && ctrl_oe == '1)); // R8
  AST_XCVR: assert property (@(posedge clk) disable iff (!rst_n)
    (xcvr_dir_n == ack_n) && (ctrl_dis_n == ack_n)); // R9
  AST_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    core_stall == !ack_n); // R10
endmodule

// File: rtl/dma_bus_arbiter.sv
module dma_bus_arbiter #(
  parameter int BUS_W  = 16,
  parameter int CTRL_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_wr,
  input  logic              io_wr_val,
  input  logic              sync_n,
  input  logic              dma_req_n,
  output logic              dma_en,
  output logic              dma_ack_n,
  output logic [BUS_W-1:0]  bus_oe,
  output logic [CTRL_W-1:0] ctrl_oe,
  output logic              xcvr_dir_n,
  output logic              ctrl_dis_n,
  output logic              core_stall
);
  logic sync_fall;
  logic gnt_nxt;
  logic gnt_q;

  dma_sync_edge u_edge (
    .clk       (clk),
    .rst_n     (rst_n),
    .sync_n    (sync_n),
    .sync_fall (sync_fall)
  );

  dma_en_reg u_en (
    .clk       (clk),
    .rst_n     (rst_n),
    .io_wr     (io_wr),
    .io_wr_val (io_wr_val),
    .en_q      (dma_en)
  );

  dma_grant_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_q      (dma_en),
    .sync_fall (sync_fall),
    .req_n     (dma_req_n),
    .gnt_nxt   (gnt_nxt),
    .gnt_q     (gnt_q)
  );

  assign dma_ack_n = ~gnt_q;

  dma_drv_ctrl #(
    .BUS_W  (BUS_W),
    .CTRL_W (CTRL_W)
  ) u_drv (
    .clk        (clk),
    .rst_n      (rst_n),
    .gnt_nxt    (gnt_nxt),
    .ack_n      (dma_ack_n),
    .bus_oe     (bus_oe),
    .ctrl_oe    (ctrl_oe),
    .xcvr_dir_n (xcvr_dir_n),
    .ctrl_dis_n (ctrl_dis_n),
    .core_stall (core_stall)
  );

  AST_ACK_ONLY_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dma_ack_n) |-> $past(sync_fall)); // R3
endmodule

// File: tb/tb_dma_bus_arbiter.sv
module tb_dma_bus_arbiter;
  localparam int BUS_W  = 16;
  localparam int CTRL_W = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic io_wr = 1'b0, io_wr_val = 1'b0, sync_n = 1'b1, dma_req_n = 1'b1;
  logic dma_en, dma_ack_n, xcvr_dir_n, ctrl_dis_n, core_stall;
  logic [BUS_W-1:0]  bus_oe;
  logic [CTRL_W-1:0] ctrl_oe;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // reference model: 0 idle, 1 pending, 2 granted
  int m_st = 0;
  bit m_en = 0;
  bit m_sync = 1;

  always #2 clk = ~clk;

  dma_bus_arbiter #(.BUS_W(BUS_W), .CTRL_W(CTRL_W)) dut (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_wr_val(io_wr_val),
    .sync_n(sync_n), .dma_req_n(dma_req_n), .dma_en(dma_en),
    .dma_ack_n(dma_ack_n), .bus_oe(bus_oe), .ctrl_oe(ctrl_oe),
    .xcvr_dir_n(xcvr_dir_n), .ctrl_dis_n(ctrl_dis_n), .core_stall(core_stall)
  );

  always @(posedge clk) begin
    bit fall;
    if (!rst_n) begin
      m_st = 0; m_en = 0; m_sync = 1;
    end else begin
      fall = m_sync && !sync_n;
      case (m_st)
        0: if (!dma_req_n && m_en) m_st = fall ? 2 : 1;
        1: if (dma_req_n) m_st = 0; else if (fall) m_st = 2;
        default: if (fall && dma_req_n) m_st = 0;
      endcase
      if (io_wr) m_en = io_wr_val;
      m_sync = sync_n;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // per-cycle comparison with the model
  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      bit g;
      g = (m_st == 2);
      chk(dma_en == m_en, "R1 dma_en", dma_en, m_en);
      chk(dma_ack_n == !g, "R3 dma_ack_n", dma_ack_n, !g);
      chk(bus_oe == {BUS_W{!g}} && ctrl_oe == {CTRL_W{!g}}, "R8 driver enables",
          int'(bus_oe), g ? 0 : (1 << BUS_W) - 1);
      chk(xcvr_dir_n == !g && ctrl_dis_n == !g, "R9 xcvr/ctrl_dis",
          {xcvr_dir_n, ctrl_dis_n}, g ? 0 : 3);
      chk(core_stall == g, "R10 core_stall", core_stall, g);
    end
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected below 100000 cycles", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr_en(input bit v);
    io_wr = 1'b1; io_wr_val = v; tick(); io_wr = 1'b0;
  endtask

  task automatic sync_fall_now();
    sync_n = 1'b0; tick(2); sync_n = 1'b1; tick(2);
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick();
    // R12 reset state
    chk(dma_ack_n && xcvr_dir_n && ctrl_dis_n && !core_stall && bus_oe == '1 && ctrl_oe == '1,
        "R12 reset state", dma_ack_n, 1);
    chk(dma_en == 1'b0, "R1 enable reset", dma_en, 0);

    // R2 request ignored while disabled
    dma_req_n = 1'b0; tick();
    sync_fall_now();
    chk(dma_ack_n == 1'b1, "R2 ignored while disabled", dma_ack_n, 1);
    dma_req_n = 1'b1; tick();

    // R1 enable write
    wr_en(1'b1); tick();
    chk(dma_en == 1'b1, "R1 enable set", dma_en, 1);

    // R4 no grant without sync edge
    dma_req_n = 1'b0; tick(6);
    chk(dma_ack_n == 1'b1, "R4 no sync edge no grant", dma_ack_n, 1);

    // R3 grant on sync fall: edge at next posedge, seen at following negedge
    sync_n = 1'b0; tick();
    chk(dma_ack_n == 1'b0, "R3 grant on sync fall", dma_ack_n, 0);
    chk(bus_oe == '0 && ctrl_oe == '0, "R8 drivers off in grant", int'(bus_oe), 0);
    chk(!xcvr_dir_n && !ctrl_dis_n, "R9 transceiver lines low", xcvr_dir_n, 0);
    chk(core_stall == 1'b1, "R10 stall in grant", core_stall, 1);
    tick(); sync_n = 1'b1; tick(2);

    // R5 release waits for sync fall
    dma_req_n = 1'b1; tick(5);
    chk(dma_ack_n == 1'b0, "R5 held until sync fall", dma_ack_n, 0);
    sync_n = 1'b0; tick();
    chk(dma_ack_n == 1'b1, "R5 released on sync fall", dma_ack_n, 1);
    chk(core_stall == 1'b0, "R10 stall cleared", core_stall, 0);
    tick(); sync_n = 1'b1; tick(2);

    // R6 pending survives enable clear
    dma_req_n = 1'b0; tick(2);
    wr_en(1'b0); tick();
    chk(dma_en == 1'b0, "R1 enable cleared", dma_en, 0);
    sync_fall_now();
    chk(dma_ack_n == 1'b0, "R6 pending still granted", dma_ack_n, 0);

    // R7 enable write during grant does not end it
    wr_en(1'b1); wr_en(1'b0); tick(3);
    sync_fall_now();
    chk(dma_ack_n == 1'b0, "R7 grant kept after disable", dma_ack_n, 0);
    dma_req_n = 1'b1; tick();
    sync_fall_now();
    chk(dma_ack_n == 1'b1, "R7 released", dma_ack_n, 1);
    dma_req_n = 1'b0; tick(2);
    sync_fall_now();
    chk(dma_ack_n == 1'b1, "R7 new request blocked", dma_ack_n, 1);
    dma_req_n = 1'b1; tick();

    // R11 cancelled pending request
    wr_en(1'b1);
    dma_req_n = 1'b0; tick(3);
    dma_req_n = 1'b1; tick(2);
    sync_fall_now();
    chk(dma_ack_n == 1'b1, "R11 cancelled request not granted", dma_ack_n, 1);

    // R3 request and sync fall in the same cycle
    dma_req_n = 1'b0; sync_n = 1'b0; tick();
    chk(dma_ack_n == 1'b0, "R3 simultaneous request and edge", dma_ack_n, 0);
    tick(); sync_n = 1'b1; dma_req_n = 1'b1; tick(2);
    sync_fall_now();
    chk(dma_ack_n == 1'b1, "R5 final release", dma_ack_n, 1);

    tick(4);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule